// File: doc/BRIEF.md
# Serial-Data-Selected Dual-Width Pulse Generator

This block turns a byte stream into a train of pulses whose widths carry the data. Software-side logic writes two compare values, A and B, which set two pulse widths measured in counter advances. A byte written into a holding register is moved into an 8-bit shift register and sent out most significant bit first. Each serial bit picks the width of one pulse: a 0 selects compare A and a 1 selects compare B.

Bit timing comes from an external baud-rate timer, which the block sees as a single-cycle tick input. Every tick moves the shift register on by one bit and restarts the pulse counter. The output rises at that restart and falls when the counter reaches the selected compare value. The counter advances on an internal or an external count enable, chosen by a select input. A single-action mode limits each bit period to exactly one rise and one fall. This keeps very short and very long duty cycles clean.

Top module: `bitsel_pwm`

## Requirements
- R1: After reset, pwm_out, byte_done and cur_bit are all 0, and both compare values are 0.
- R2: A baud_tick restarts the pulse counter. When the compare value selected for the new bit is not zero, pwm_out is 1 in the cycle after the tick and stays high for exactly that many counter advances.
- R3: cur_bit = 0 selects compare A (written with wr_cmp_a) and cur_bit = 1 selects compare B (written with wr_cmp_b). Both take their value from wr_data.
- R4: A byte written with load_data is sent MSB first. The tick that follows the write makes bit 7 current, and each later tick makes the next lower bit current. cur_bit changes only in the cycle after a tick.
- R5: The tick that ends the eighth bit of a byte raises byte_done for one cycle. If a new byte is pending, that same tick makes its bit 7 current. Otherwise the shifter goes idle and cur_bit reads 0.
- R6: A selected compare value of zero keeps pwm_out low for the whole bit period.
- R7: A selected compare value equal to or larger than the number of advances in the period keeps pwm_out high for the whole period, provided the period is shorter than 2^CW advances.
- R8: With single_shot = 0, the counter wraps modulo 2^CW. A wrap raises pwm_out again when the selected compare is not zero, so a period longer than 2^CW advances repeats the pulse.
- R9: With single_shot = 1, each period has one rise, at the tick, and at most one fall. Counter wraps and later matches in that period leave pwm_out unchanged.
- R10: clk_sel = 0 advances the counter on cnt_en_int and clk_sel = 1 advances it on cnt_en_ext. The unselected enable has no effect, and without an advance or a tick pwm_out does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en_int | input | 1 | Internal counter advance enable |
| cnt_en_ext | input | 1 | External counter advance enable |
| clk_sel | input | 1 | Advance source: 0 internal, 1 external |
| single_shot | input | 1 | Single-action mode |
| wr_cmp_a | input | 1 | Write wr_data into compare A |
| wr_cmp_b | input | 1 | Write wr_data into compare B |
| wr_data | input | CW | Compare write data |
| load_data | input | 1 | Write load_byte into the holding register |
| load_byte | input | DW | Byte to transmit |
| baud_tick | input | 1 | Bit-period tick from the baud-rate timer |
| pwm_out | output | 1 | Pulse output |
| cur_bit | output | 1 | Bit currently selecting the width |
| byte_done | output | 1 | One-cycle pulse after the last bit of a byte |

## Verification
Every result is registered once after the edge that causes it. pwm_out rises in the cycle right after a tick edge and falls in the cycle after the advance that brings the count to the selected compare value. cur_bit and byte_done change in the cycle after the tick edge. The bench changes inputs and samples outputs on the falling edge. For each period it counts the high samples from the first sample after the tick edge up to the sample just before the next tick edge, so the expected count is min(compare, advances), with the wrap and clock-select cases worked out from the same rule. cur_bit and byte_done are read in that first sample of each period.

// File: rtl/bitsel_pwm_pkg.sv
package bitsel_pwm_pkg;
   localparam int NUM_CMP = 2;

   typedef enum logic {
      ADV_INTERNAL = 1'b0,
      ADV_EXTERNAL = 1'b1
   } adv_src_e;
endpackage

// File: rtl/bitsel_pwm_cmpbank.sv
module bitsel_pwm_cmpbank #(
   parameter int CW  = 8,
   parameter int NUM = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM-1:0]          wr,
   input  logic [CW-1:0]           wdata,
   output logic [NUM-1:0][CW-1:0]  value
);
   for (genvar i = 0; i < NUM; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            value[i] <= '0;
         else if (wr[i])
            value[i] <= wdata;
      end
   end
endmodule

// File: rtl/bitsel_pwm_shifter.sv
module bitsel_pwm_shifter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_byte,
   input  logic          tick,
   output logic          cur_bit,
   output logic          bit_next,
   output logic          byte_done
);
   localparam int RW = (DW > 2) ? $clog2(DW) : 1;
   localparam logic [RW-1:0] LAST_IDX = RW'(DW - 1);

   logic [DW-1:0] shreg;
   logic [DW-1:0] hold;
   logic          pending;
   logic          active;
   logic [RW-1:0] remain;
   logic          boundary;

   assign boundary = tick && (!active || (remain == '0));
   assign cur_bit  = shreg[DW-1];

   always_comb begin
      if (boundary)
         bit_next = pending ? hold[DW-1] : 1'b0;
      else if (tick)
         bit_next = shreg[DW-2];
      else
         bit_next = shreg[DW-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg     <= '0;
         hold      <= '0;
         pending   <= 1'b0;
         active    <= 1'b0;
         remain    <= '0;
         byte_done <= 1'b0;
      end else begin
         if (load)
            hold <= load_byte;
         pending <= (pending && !boundary) || load;
         if (boundary) begin
            byte_done <= active;
            if (pending) begin
               shreg  <= hold;
               remain <= LAST_IDX;
               active <= 1'b1;
            end else begin
               shreg  <= '0;
               remain <= '0;
               active <= 1'b0;
            end
         end else if (tick) begin
            byte_done <= 1'b0;
            shreg     <= {shreg[DW-2:0], 1'b0};
            remain    <= remain - RW'(1);
         end else begin
            byte_done <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bitsel_pwm_pulse.sv
module bitsel_pwm_pulse #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          adv,
   input  logic          single,
   input  logic [CW-1:0] cmp_now,
   input  logic [CW-1:0] cmp_next,
   output logic          pwm
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;
   logic          acted;
   logic          locked;
   logic          hit;
   logic          wrap;

   assign cnt_inc = cnt + CW'(1);
   assign locked  = single && acted;
   assign hit     = (cmp_now != '0) && (cnt_inc == cmp_now);
   assign wrap    = (cnt_inc == '0) && !single && (cmp_now != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         acted <= 1'b0;
         pwm   <= 1'b0;
      end else if (tick) begin
         cnt   <= '0;
         acted <= 1'b0;
         pwm   <= (cmp_next != '0);
      end else if (adv) begin
         cnt <= cnt_inc;
         if (!locked) begin
            if (hit) begin
               pwm   <= 1'b0;
               acted <= 1'b1;
            end else if (wrap) begin
               pwm   <= 1'b1;
               acted <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/bitsel_pwm.sv
module bitsel_pwm
   import bitsel_pwm_pkg::*;
#(
   parameter int CW         = 8,
   parameter int DW         = 8,
   parameter bit HAS_EXT_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cnt_en_int,
   input  logic          cnt_en_ext,
   input  logic          clk_sel,
   input  logic          single_shot,
   input  logic          wr_cmp_a,
   input  logic          wr_cmp_b,
   input  logic [CW-1:0] wr_data,
   input  logic          load_data,
   input  logic [DW-1:0] load_byte,
   input  logic          baud_tick,
   output logic          pwm_out,
   output logic          cur_bit,
   output logic          byte_done
);
   if (CW < 2) begin : g_bad_cw
      $error("bitsel_pwm: CW must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("bitsel_pwm: DW must be at least 2");
   end

   logic [NUM_CMP-1:0][CW-1:0] cmp_val;
   logic                       bit_next;
   logic                       cnt_adv;
   logic [CW-1:0]              cmp_now;
   logic [CW-1:0]              cmp_next;

   if (HAS_EXT_EN) begin : g_adv_sel
      assign cnt_adv = (adv_src_e'(clk_sel) == ADV_EXTERNAL) ? cnt_en_ext : cnt_en_int;
   end else begin : g_adv_int
      assign cnt_adv = cnt_en_int;
   end

   bitsel_pwm_cmpbank #(.CW(CW), .NUM(NUM_CMP)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    ({wr_cmp_b, wr_cmp_a}),
      .wdata (wr_data),
      .value (cmp_val)
   );

   bitsel_pwm_shifter #(.DW(DW)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_data),
      .load_byte (load_byte),
      .tick      (baud_tick),
      .cur_bit   (cur_bit),
      .bit_next  (bit_next),
      .byte_done (byte_done)
   );

   assign cmp_now  = cmp_val[cur_bit];
   assign cmp_next = cmp_val[bit_next];

   bitsel_pwm_pulse #(.CW(CW)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .adv      (cnt_adv),
      .single   (single_shot),
      .cmp_now  (cmp_now),
      .cmp_next (cmp_next),
      .pwm      (pwm_out)
   );
endmodule

// File: rtl/bitsel_pwm_chk.sv
module bitsel_pwm_chk #(
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          baud_tick,
   input logic          adv,
   input logic          single_shot,
   input logic          pwm_out,
   input logic          cur_bit,
   input logic          byte_done,
   input logic [CW-1:0] cmp_next
);
   p_tick_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_tick && (cmp_next != '0)) |=> pwm_out);

   p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_tick && (cmp_next == '0)) |=> !pwm_out);

   p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(cur_bit));

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> !byte_done);

   p_single_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (single_shot && !pwm_out && !baud_tick) |=> !pwm_out);

   p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!baud_tick && !adv) |=> $stable(pwm_out));
endmodule

bind bitsel_pwm bitsel_pwm_chk #(.CW(CW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .baud_tick   (baud_tick),
   .adv         (cnt_adv),
   .single_shot (single_shot),
   .pwm_out     (pwm_out),
   .cur_bit     (cur_bit),
   .byte_done   (byte_done),
   .cmp_next    (cmp_next)
);

// File: tb/sim_bitsel_pwm.sv
module sim_bitsel_pwm;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cnt_en_int = 1'b1;
   logic          cnt_en_ext = 1'b0;
   logic          clk_sel = 1'b0;
   logic          single_shot = 1'b0;
   logic          wr_cmp_a = 1'b0;
   logic          wr_cmp_b = 1'b0;
   logic [CW-1:0] wr_data = '0;
   logic          load_data = 1'b0;
   logic [DW-1:0] load_byte = '0;
   logic          baud_tick = 1'b0;
   logic          pwm_out;
   logic          cur_bit;
   logic          byte_done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int p_high;
   logic p_bit;
   logic p_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitsel_pwm #(.CW(CW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_en_int(cnt_en_int), .cnt_en_ext(cnt_en_ext),
      .clk_sel(clk_sel), .single_shot(single_shot), .wr_cmp_a(wr_cmp_a),
      .wr_cmp_b(wr_cmp_b), .wr_data(wr_data), .load_data(load_data),
      .load_byte(load_byte), .baud_tick(baud_tick), .pwm_out(pwm_out),
      .cur_bit(cur_bit), .byte_done(byte_done)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic write_cmp(input bit sel_b, input int val);
      @(negedge clk);
      wr_data  = CW'(val);
      wr_cmp_a = !sel_b;
      wr_cmp_b = sel_b;
      @(negedge clk);
      wr_cmp_a = 1'b0;
      wr_cmp_b = 1'b0;
   endtask

   task automatic load(input logic [DW-1:0] b);
      @(negedge clk);
      load_byte = b;
      load_data = 1'b1;
      @(negedge clk);
      load_data = 1'b0;
   endtask

   // One bit period of len cycles started by a tick; counts high samples.
   task automatic period(input int len);
      @(negedge clk);
      baud_tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      baud_tick = 1'b0;
      p_bit  = cur_bit;
      p_done = byte_done;
      p_high = int'(pwm_out);
      for (int i = 1; i < len; i++) begin
         @(negedge clk);
         p_high += int'(pwm_out);
      end
   endtask

   task automatic t_reset();
      check("R1", "pwm_out after reset", int'(pwm_out), 0);
      check("R1", "byte_done after reset", int'(byte_done), 0);
      check("R1", "cur_bit after reset", int'(cur_bit), 0);
      period(6);
      check("R1", "compare zero after reset gives no pulse", p_high, 0);
   endtask

   task automatic t_stream();
      logic [15:0] bits = 16'hA53C;
      write_cmp(1'b0, 3);
      write_cmp(1'b1, 7);
      load(8'hA5);
      for (int k = 0; k < 16; k++) begin
         period(12);
         if (k == 1) load(8'h3C);
         check("R4", $sformatf("cur_bit of bit %0d", k), int'(p_bit), int'(bits[15-k]));
         check("R3", $sformatf("width of bit %0d (R2)", k), p_high, bits[15-k] ? 7 : 3);
         check("R5", $sformatf("byte_done at bit %0d", k), int'(p_done), (k == 8) ? 1 : 0);
      end
      period(12);
      check("R5", "byte_done after last byte", int'(p_done), 1);
      check("R5", "idle bit reads 0", int'(p_bit), 0);
      period(12);
      check("R5", "byte_done single pulse", int'(p_done), 0);
   endtask

   task automatic t_extremes();
      write_cmp(1'b0, 0);
      period(12);
      check("R6", "compare zero stays low", p_high, 0);
      write_cmp(1'b0, 12);
      period(12);
      check("R7", "compare equal to period stays high", p_high, 12);
      write_cmp(1'b0, 200);
      period(15);
      check("R7", "compare above period stays high", p_high, 15);
      write_cmp(1'b0, 1);
      period(15);
      check("R2", "compare one gives one cycle", p_high, 1);
   endtask

   task automatic t_wrap();
      write_cmp(1'b0, 10);
      single_shot = 1'b0;
      period(300);
      check("R8", "wrap repeats pulse", p_high, 20);
      single_shot = 1'b1;
      period(300);
      check("R9", "single action one pulse", p_high, 10);
      single_shot = 1'b0;
   endtask

   task automatic t_clksel();
      write_cmp(1'b0, 5);
      clk_sel = 1'b1; cnt_en_int = 1'b1; cnt_en_ext = 1'b0;
      period(20);
      check("R10", "external selected, held off", p_high, 20);
      clk_sel = 1'b0; cnt_en_int = 1'b0; cnt_en_ext = 1'b1;
      period(20);
      check("R10", "internal selected, held off", p_high, 20);
      clk_sel = 1'b1;
      period(20);
      check("R10", "external selected, running", p_high, 5);
      clk_sel = 1'b0; cnt_en_int = 1'b1; cnt_en_ext = 1'b0;
      period(20);
      check("R10", "internal selected, running", p_high, 5);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stream();
      t_extremes();
      t_wrap();
      t_clksel();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule